// File: doc/BRIEF.md
# Bidirectional Switch-Attenuator Cell

This cell models one transistor at switch level as a controlled two-way path with a fixed on-state resistance. It has a one-way control input and two terminals, `a` and `b`. Each terminal carries an incoming and an outgoing signal made of a level and a strength. The level code is 0 = logic 0, 1 = logic 1, 2 = unknown (U) and 3 = undriven (Z). The strength is an index from 0 (strongest) to `N_STR` (no current). The value (Z, `N_STR`) is the undriven signal.

When the path conducts, each terminal sends out what arrives at the opposite terminal. The level is kept, and the strength is clamped to be no stronger than the cell's attenuation. When the path is open, both terminals send out the undriven signal. The on-state attenuation is built from two parameter sizes. They are combined as a series pair (the larger index wins) or a parallel pair (the smaller index wins). A parameter selects positive or negative control sense.

Results are registered, so each output appears one clock after its inputs. A node-resolution stage elsewhere combines the outgoing signals with other drivers.

Top module: `sw_atten_cell`

## Requirements
- R1: With `POSITIVE`=1, a control level of 1 closes the path and a control level of 0 opens it, whatever the control strength.
- R2: With `POSITIVE`=0, a control level of 0 closes the path and a control level of 1 opens it, whatever the control strength.
- R3: When closed, `a_out` takes its level from `b_in` and `b_out` takes its level from `a_in`. The two directions are computed independently (level codes 0=0, 1=1, 2=U, 3=Z).
- R4: When closed, each transferred strength is the larger index of the incoming strength and the effective attenuation.
- R5: When open, both outputs are (3, `N_STR`).
- R6: An effective attenuation of 0 passes every driven signal unchanged.
- R7: The effective attenuation is max(`ATT_P`, `ATT_Q`) when `SERIES`=1 and min(`ATT_P`, `ATT_Q`) when `SERIES`=0.
- R8: A control level of U (2) or Z (3) sets an output to (2, larger index of incoming strength and attenuation) if the opposite input is driven. Otherwise that output is (3, `N_STR`).
- R9: An incoming signal with level 3, or with strength `N_STR` or weaker, produces (3, `N_STR`) on the opposite output. Any output whose clamped strength reaches `N_STR` is also (3, `N_STR`).
- R10: Outputs change one clock after the inputs. While `rst_n` is low at a clock edge, both outputs become (3, `N_STR`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_lvl | input | 2 | Control level code |
| ctl_str | input | SW | Control strength (does not affect decoding) |
| a_in_lvl | input | 2 | Level arriving at terminal a |
| a_in_str | input | SW | Strength arriving at terminal a |
| b_in_lvl | input | 2 | Level arriving at terminal b |
| b_in_str | input | SW | Strength arriving at terminal b |
| a_out_lvl | output | 2 | Level leaving terminal a |
| a_out_str | output | SW | Strength leaving terminal a |
| b_out_lvl | output | 2 | Level leaving terminal b |
| b_out_str | output | SW | Strength leaving terminal b |

## Verification
Both transfer directions are evaluated in the same cycle. An unknown control can also meet an undriven input on one side and a driven input on the other. The bench drives independent random and directed values on both terminals at once, including cases where one side is undriven while the other is strong. Each output is compared on every clock against a behavioural model, for three instances with different polarity, attenuation and combining rule. A fault in one direction or in the clamp therefore shows up even when the other direction is correct.

// File: rtl/sw_pkg.sv
// Shared types and helpers for the switch-attenuator cell.
// Assumes a level is coded on two bits and that strength index 0 is the strongest.
package sw_pkg;

    typedef enum logic [1:0] {
        LV_0 = 2'd0,
        LV_1 = 2'd1,
        LV_U = 2'd2,
        LV_Z = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        CT_OPEN   = 2'd0,
        CT_CLOSED = 2'd1,
        CT_UNSURE = 2'd2
    } ctl_e;

    // Combines two attenuator sizes. A series pair keeps the larger size and a parallel pair keeps the smaller (R7).
    function automatic int unsigned att_combine(input int unsigned x,
                                                input int unsigned y,
                                                input bit series);
        if (series) return (x > y) ? x : y;
        return (x < y) ? x : y;
    endfunction

endpackage

// File: rtl/sw_ctrl_decode.sv
// Turns the control level into a path state for the selected polarity.
// Assumes the control strength never changes the decision.
module sw_ctrl_decode #(
    parameter bit POSITIVE = 1'b1
) (
    input  logic [1:0]  ctl_lvl,
    output sw_pkg::ctl_e mode
);
    import sw_pkg::*;

    localparam logic [1:0] ON_CODE  = POSITIVE ? 2'd1 : 2'd0;
    localparam logic [1:0] OFF_CODE = POSITIVE ? 2'd0 : 2'd1;

    // Maps the control level to open, closed or unsure.
    always_comb begin
        if (ctl_lvl == ON_CODE)       mode = CT_CLOSED;
        else if (ctl_lvl == OFF_CODE) mode = CT_OPEN;
        else                          mode = CT_UNSURE;
    end

endmodule

// File: rtl/sw_path_limit.sv
// One transfer direction: it carries an incoming signal to the opposite terminal
// and clamps its strength at the cell attenuation.
// Assumes the incoming strength may take any code the width allows.
module sw_path_limit #(
    parameter int unsigned N_STR = 3,
    parameter int unsigned ATT   = 1,
    parameter int unsigned SW    = 2
) (
    input  sw_pkg::ctl_e   mode,
    input  logic [1:0]     in_lvl,
    input  logic [SW-1:0]  in_str,
    output logic [1:0]     out_lvl,
    output logic [SW-1:0]  out_str
);
    import sw_pkg::*;

    localparam logic [SW-1:0] WEAK  = SW'(N_STR);
    localparam logic [SW-1:0] ATT_S = SW'(ATT);

    logic          driven;
    logic [SW-1:0] clamped;

    // An input counts as driven only when it has a level and some current.
    always_comb driven = (in_lvl != LV_Z) && (in_str < WEAK);

    // Keeps the weaker of the incoming strength and the attenuation.
    always_comb clamped = (in_str > ATT_S) ? in_str : ATT_S;

    // Forms the outgoing pair from the path state.
    always_comb begin
        out_lvl = LV_Z;
        out_str = WEAK;
        if (driven && clamped < WEAK) begin
            case (mode)
                CT_CLOSED: begin
                    out_lvl = in_lvl;
                    out_str = clamped;
                end
                CT_UNSURE: begin
                    out_lvl = LV_U;
                    out_str = clamped;
                end
                default: begin
                    out_lvl = LV_Z;
                    out_str = WEAK;
                end
            endcase
        end
    end

endmodule

// File: rtl/sw_atten_cell.sv
// Top level of the switch-attenuator cell: a control decoder, two transfer
// paths (a to b and b to a) and an output register stage.
// Assumes ATT_P and ATT_Q are no larger than N_STR. Reset is synchronous and active low.
module sw_atten_cell #(
    parameter int unsigned N_STR    = 3,
    parameter int unsigned ATT_P    = 1,
    parameter int unsigned ATT_Q    = 2,
    parameter bit          SERIES   = 1'b1,
    parameter bit          POSITIVE = 1'b1,
    parameter int unsigned SW       = $clog2(N_STR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ctl_lvl,
    input  logic [SW-1:0] ctl_str,
    input  logic [1:0]    a_in_lvl,
    input  logic [SW-1:0] a_in_str,
    input  logic [1:0]    b_in_lvl,
    input  logic [SW-1:0] b_in_str,
    output logic [1:0]    a_out_lvl,
    output logic [SW-1:0] a_out_str,
    output logic [1:0]    b_out_lvl,
    output logic [SW-1:0] b_out_str
);
    import sw_pkg::*;

    localparam int unsigned   EFF_ATT = att_combine(ATT_P, ATT_Q, SERIES);
    localparam logic [SW-1:0] WEAK    = SW'(N_STR);
    localparam logic [SW-1:0] EFF_S   = SW'(EFF_ATT);

    ctl_e          mode;
    logic [1:0]    src_lvl [2];
    logic [SW-1:0] src_str [2];
    logic [1:0]    nxt_lvl [2];
    logic [SW-1:0] nxt_str [2];
    logic          ctl_str_unused;

    // The control strength takes no part in decoding.
    always_comb ctl_str_unused = ^ctl_str;

    sw_ctrl_decode #(.POSITIVE(POSITIVE)) u_dec (
        .ctl_lvl (ctl_lvl),
        .mode    (mode)
    );

    // Entry 0 feeds terminal a (source b) and entry 1 feeds terminal b (source a).
    always_comb begin
        src_lvl[0] = b_in_lvl;
        src_str[0] = b_in_str;
        src_lvl[1] = a_in_lvl;
        src_str[1] = a_in_str;
    end

    for (genvar d = 0; d < 2; d++) begin : g_dir
        sw_path_limit #(.N_STR(N_STR), .ATT(EFF_ATT), .SW(SW)) u_path (
            .mode    (mode),
            .in_lvl  (src_lvl[d]),
            .in_str  (src_str[d]),
            .out_lvl (nxt_lvl[d]),
            .out_str (nxt_str[d])
        );
    end

    // Registers both outputs and loads the undriven value during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_out_lvl <= LV_Z;
            a_out_str <= WEAK;
            b_out_lvl <= LV_Z;
            b_out_str <= WEAK;
        end else begin
            a_out_lvl <= nxt_lvl[0];
            a_out_str <= nxt_str[0];
            b_out_lvl <= nxt_lvl[1];
            b_out_str <= nxt_str[1];
        end
    end

    p_reset_undriven_r10: assert property (@(posedge clk)
        !rst_n |=> (a_out_lvl == LV_Z && a_out_str == WEAK && b_out_lvl == LV_Z && b_out_str == WEAK));

    p_open_undriven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CT_OPEN) |=> (a_out_lvl == LV_Z && a_out_str == WEAK && b_out_lvl == LV_Z && b_out_str == WEAK));

    p_level_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CT_CLOSED && b_in_lvl != LV_Z && b_in_str < EFF_S) |=> (a_out_lvl == $past(b_in_lvl)));

    p_strength_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_out_lvl != LV_Z) |-> (a_out_str >= EFF_S && a_out_str < WEAK));

    p_unsure_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CT_UNSURE) |=> ((a_out_lvl == LV_U || a_out_lvl == LV_Z) && (b_out_lvl == LV_U || b_out_lvl == LV_Z)));

    p_float_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_in_lvl == LV_Z) |=> (b_out_lvl == LV_Z && b_out_str == WEAK));

endmodule

// File: tb/sw_atten_cell_test.sv
// Bench for the switch-attenuator cell. Three instances with different
// polarity, attenuation and combining rule are compared each cycle with a behavioural model.
module sw_atten_cell_test;

    localparam int NS = 3;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ctl_lvl = 2'd0;
    logic [SW-1:0] ctl_str = '0;
    logic [1:0]    a_in_lvl = 2'd3;
    logic [SW-1:0] a_in_str = SW'(NS);
    logic [1:0]    b_in_lvl = 2'd3;
    logic [SW-1:0] b_in_str = SW'(NS);

    logic [1:0]    ol [3][2];
    logic [SW-1:0] os [3][2];

    int tests = 0;
    int fails = 0;
    int exp_l [3][2];
    int exp_s [3][2];
    string exp_t [3][2];

    always #4 clk = ~clk;   // 125 MHz

    // R7: each instance's effective size is worked out here from its own two sizes.
    function automatic int eff_of(int p, int q, bit series);
        if (series) return (p > q) ? p : q;
        return (p < q) ? p : q;
    endfunction

    int pol [3] = '{1, 0, 1};
    int eff [3];

    sw_atten_cell #(.N_STR(NS), .ATT_P(1), .ATT_Q(2), .SERIES(1'b1), .POSITIVE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_lvl(ctl_lvl), .ctl_str(ctl_str),
        .a_in_lvl(a_in_lvl), .a_in_str(a_in_str), .b_in_lvl(b_in_lvl), .b_in_str(b_in_str),
        .a_out_lvl(ol[0][0]), .a_out_str(os[0][0]), .b_out_lvl(ol[0][1]), .b_out_str(os[0][1]));

    sw_atten_cell #(.N_STR(NS), .ATT_P(2), .ATT_Q(1), .SERIES(1'b0), .POSITIVE(1'b0)) uut_neg (
        .clk(clk), .rst_n(rst_n), .ctl_lvl(ctl_lvl), .ctl_str(ctl_str),
        .a_in_lvl(a_in_lvl), .a_in_str(a_in_str), .b_in_lvl(b_in_lvl), .b_in_str(b_in_str),
        .a_out_lvl(ol[1][0]), .a_out_str(os[1][0]), .b_out_lvl(ol[1][1]), .b_out_str(os[1][1]));

    sw_atten_cell #(.N_STR(NS), .ATT_P(0), .ATT_Q(0), .SERIES(1'b1), .POSITIVE(1'b1)) uut_ideal (
        .clk(clk), .rst_n(rst_n), .ctl_lvl(ctl_lvl), .ctl_str(ctl_str),
        .a_in_lvl(a_in_lvl), .a_in_str(a_in_str), .b_in_lvl(b_in_lvl), .b_in_str(b_in_str),
        .a_out_lvl(ol[2][0]), .a_out_str(os[2][0]), .b_out_lvl(ol[2][1]), .b_out_str(os[2][1]));

    // Behavioural expectation for one output, with the requirement it exercises.
    task automatic model(input int k, input int cl, input int il, input int is,
                         output int el, output int es, output string tg);
        bit drv = (il != 3) && (is < NS);
        int lim = (is > eff[k]) ? is : eff[k];
        string pt = pol[k] ? "R1" : "R2";
        el = 3; es = NS;
        if (cl >= 2) begin
            tg = "R8";
            if (drv && lim < NS) begin el = 2; es = lim; end
        end else if ((pol[k] != 0) != (cl == 1)) begin
            tg = {pt, "/R5"};
        end else if (!drv || lim >= NS) begin
            tg = {pt, "/R9"};
        end else begin
            el = il; es = lim;
            if (eff[k] == 0) tg = {pt, "/R6"};
            else if (is == 0) tg = {pt, "/R3/R7"};
            else tg = {pt, "/R3/R4"};
        end
    endtask

    // Compares all outputs, then applies the next inputs and records their expectation.
    task automatic step(input bit rv, input int cl, input int cs,
                        input int al, input int as_, input int bl, input int bs);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            for (int d = 0; d < 2; d++) begin
                tests++;
                if (int'(ol[k][d]) != exp_l[k][d] || int'(os[k][d]) != exp_s[k][d]) begin
                    fails++;
                    $display("FAIL %s inst%0d %s: got (%0d,%0d) expected (%0d,%0d)",
                             exp_t[k][d], k, d ? "b_out" : "a_out",
                             ol[k][d], os[k][d], exp_l[k][d], exp_s[k][d]);
                end
            end
        end
        rst_n = rv;
        ctl_lvl = 2'(cl); ctl_str = SW'(cs);
        a_in_lvl = 2'(al); a_in_str = SW'(as_);
        b_in_lvl = 2'(bl); b_in_str = SW'(bs);
        for (int k = 0; k < 3; k++) begin
            if (!rv) begin
                exp_l[k][0] = 3; exp_s[k][0] = NS; exp_t[k][0] = "R10";
                exp_l[k][1] = 3; exp_s[k][1] = NS; exp_t[k][1] = "R10";
            end else begin
                model(k, cl, bl, bs, exp_l[k][0], exp_s[k][0], exp_t[k][0]);
                model(k, cl, al, as_, exp_l[k][1], exp_s[k][1], exp_t[k][1]);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not end (got hang, expected completion)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        eff[0] = eff_of(1, 2, 1'b1);
        eff[1] = eff_of(2, 1, 1'b0);
        eff[2] = eff_of(0, 0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            for (int d = 0; d < 2; d++) begin
                exp_l[k][d] = 3; exp_s[k][d] = NS; exp_t[k][d] = "R10";
            end
        end
        // Reset: inputs that would conduct must not reach the outputs (R10).
        step(1'b0, 1, 0, 1, 0, 0, 0);
        step(1'b0, 0, 0, 0, 0, 1, 0);
        step(1'b0, 1, 3, 1, 0, 0, 1);
        // Directed: strong opposite levels crossing in both directions at once.
        step(1'b1, 1, 0, 1, 0, 0, 0);
        step(1'b1, 0, 0, 1, 0, 0, 0);
        step(1'b1, 1, 3, 0, 1, 1, 2);
        step(1'b1, 0, 3, 2, 0, 1, 1);
        // One side undriven, the other side strong (R9).
        step(1'b1, 1, 0, 3, 0, 1, 0);
        step(1'b1, 0, 0, 1, 3, 3, 3);
        // Unknown control with one driven and one undriven side (R8).
        step(1'b1, 2, 0, 1, 0, 3, 3);
        step(1'b1, 3, 1, 3, 1, 0, 1);
        // Weak input already past the attenuation (R4).
        step(1'b1, 1, 0, 1, 2, 0, 2);
        // A reset pulse in mid-run (R10).
        step(1'b0, 1, 0, 1, 0, 1, 0);
        step(1'b1, 1, 0, 0, 1, 1, 1);
        for (int n = 0; n < 3000; n++) begin
            step(1'b1, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
        end
        step(1'b1, 0, 0, 3, 3, 3, 3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule